// File: doc/BRIEF.md
# Keyed Watchdog Timer with Binary Prescaler

This block is a watchdog for a small controller. It counts a slow timebase, which is a one-cycle enable that pulses at 250 kHz. A 4-bit divider select sets a power-of-two prescaler from 1 to 32768. The prescaler drives a timeout counter that is `CNT_W` bits wide (8 by default). If software does not refresh the watchdog before that counter passes its top value, the block raises a one-cycle system reset request and records a sticky cause flag. With the default width, the timeout runs from 256 ticks (about 1.02 ms) to 256·32768 ticks (about 33.55 s).

Software reaches the block through a simple register bus with two addresses. One is a control register holding the flag, the enable and the divider select. The other is a refresh register that only reacts to one key byte. Control writes go through only while the unlock input is high. A static configuration input turns the watchdog off no matter what the enable bit holds.

A small state machine sequences the block. **ST_IDLE** moves to **ST_COUNT** when the watchdog becomes active (enable set and force-off low). **ST_COUNT** returns to **ST_IDLE** when it becomes inactive, and moves to **ST_TRIP** on an overflow that no refresh cancels. **ST_TRIP** lasts one cycle and drives the reset request. It then goes back to **ST_COUNT** if the block is still active, and to **ST_IDLE** otherwise.

Top module: `wdk_top`

## Requirements
- R1: After `rst_n` is low, the control register (address 0) reads 04h: flag 0, enable 0, divider select 4. The reset request is low.
- R2: Once the count has been cleared, `wdt_rst_req` rises after exactly 2^CNT_W · 2^N ticks, where N is the divider select in control bits [3:0]. It stays high for one cycle. If the watchdog remains active, it fires again every period.
- R3: A write of exactly 55h to address 1 clears the prescaler and the timeout counter, and it wins over an overflow in the same cycle. A write of any other value to address 1 changes nothing.
- R4: Control bit 7 is set by hardware in the same cycle the reset request rises. A timeout does not clear it. Writing the control register with bit 7 at 0 clears it, and `rst_n` clears it.
- R5: While `cfg_wdt_off` is 1, the counters stay cleared and no reset request is made, whatever control bit 6 holds.
- R6: A control write while `ctl_unlock` is 0 leaves the control register unchanged.
- R7: An accepted control write that changes bits [3:0] clears the prescaler and the counter, so the new period starts in full from that write.
- R8: Address 1 reads 00h. Control bits [5:4] read 0.
- R9: The counters advance only in cycles where `tick_en` is 1.
- R10: With control bit 6 at 0, no reset request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on or external reset |
| tick_en | input | 1 | 250 kHz timebase enable, one cycle wide |
| cfg_wdt_off | input | 1 | Static configuration: 1 forces the watchdog off |
| ctl_unlock | input | 1 | 1 allows control-register writes |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = control register, 1 = refresh register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with `CNT_W` = 4 and keeps the divider select at its full 4 bits. With the timebase held high, a period is 16·2^N cycles. That brings select values 0, 1, 3 and 4 within a few hundred cycles, so the bench can check exact periods, back-to-back timeouts, a refresh in the middle of a period and a change of divider. Holding the timebase low shows that the count stops.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam int SEL_W = 4;

    localparam logic       ADDR_CTL    = 1'b0;
    localparam logic       ADDR_KEY    = 1'b1;
    localparam logic [7:0] REFRESH_KEY = 8'h55;
    localparam logic [3:0] SEL_RESET   = 4'd4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TRIP  = 2'd2
    } wdk_state_e;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_unlock,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    input  logic             trip_evt,
    output logic             flag_q,
    output logic             en_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             refresh_hit,
    output logic             sel_change,
    output logic [7:0]       bus_rdata
);
    logic ctl_wr;
    logic key_wr;

    assign ctl_wr      = bus_wr && (bus_addr == ADDR_CTL) && ctl_unlock;
    assign key_wr      = bus_wr && (bus_addr == ADDR_KEY);
    assign refresh_hit = key_wr && (bus_wdata == REFRESH_KEY);
    assign sel_change  = ctl_wr && (bus_wdata[SEL_W-1:0] != sel_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= SEL_RESET;
        end else if (ctl_wr) begin
            en_q  <= bus_wdata[6];
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (trip_evt) begin
            flag_q <= 1'b1;
        end else if (ctl_wr && !bus_wdata[7]) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (bus_addr == ADDR_CTL) begin
            bus_rdata = {flag_q, en_q, 2'b00, sel_q};
        end
    end
endmodule

// File: rtl/wdk_prescaler.sv
module wdk_prescaler
    import wdk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             stride
);
    localparam int PRE_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    assign mask   = ~({PRE_W{1'b1}} << sel);
    assign stride = tick && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdk_timeout.sv
module wdk_timeout #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    output logic ovf
);
    logic [CNT_W-1:0] cnt_q;

    assign ovf = step && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdk_fsm.sv
module wdk_fsm
    import wdk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ovf,
    input  logic soft_clr,
    output logic trip_evt,
    output logic rst_req
);
    wdk_state_e state_q;
    wdk_state_e state_d;

    assign trip_evt = (state_q == ST_COUNT) && active && ovf && !soft_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (active) state_d = ST_COUNT;
            ST_COUNT: begin
                if (!active)       state_d = ST_IDLE;
                else if (trip_evt) state_d = ST_TRIP;
            end
            ST_TRIP:  state_d = active ? ST_COUNT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rst_req = (state_q == ST_TRIP);
    end
endmodule

// File: rtl/wdk_top.sv
module wdk_top
    import wdk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       cfg_wdt_off,
    input  logic       ctl_unlock,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       wdt_rst_req
);
    logic             ctl_flag;
    logic             ctl_en;
    logic [SEL_W-1:0] ctl_sel;
    logic             refresh_hit;
    logic             sel_change;
    logic             soft_clr;
    logic             active;
    logic             trip_evt;
    logic             cnt_clr;
    logic             stride;
    logic             ovf;

    assign active   = ctl_en && !cfg_wdt_off;
    assign soft_clr = refresh_hit || sel_change;
    assign cnt_clr  = !active || soft_clr || trip_evt;

    wdk_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_unlock  (ctl_unlock),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .trip_evt    (trip_evt),
        .flag_q      (ctl_flag),
        .en_q        (ctl_en),
        .sel_q       (ctl_sel),
        .refresh_hit (refresh_hit),
        .sel_change  (sel_change),
        .bus_rdata   (bus_rdata)
    );

    wdk_prescaler u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .tick   (tick_en),
        .sel    (ctl_sel),
        .stride (stride)
    );

    wdk_timeout #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .step  (stride),
        .ovf   (ovf)
    );

    wdk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .ovf      (ovf),
        .soft_clr (soft_clr),
        .trip_evt (trip_evt),
        .rst_req  (wdt_rst_req)
    );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wdt_off,
    input logic             ctl_unlock,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [7:0]       bus_wdata,
    input logic [7:0]       bus_rdata,
    input logic             wdt_rst_req,
    input logic             ctl_flag,
    input logic             ctl_en,
    input logic [SEL_W-1:0] ctl_sel
);
    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |=> !wdt_rst_req); // R2

    AST_FLAG_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_req |-> ctl_flag); // R4

    AST_FORCED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wdt_off && $past(cfg_wdt_off)) |-> !wdt_rst_req); // R5

    AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CTL && !ctl_unlock) |=> $stable({ctl_en, ctl_sel})); // R6

    AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_KEY) |-> (bus_rdata == 8'h00)); // R8

    AST_REFRESH_NO_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_KEY && bus_wdata == REFRESH_KEY) |=> !wdt_rst_req); // R3

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_en && $past(!ctl_en)) |-> !wdt_rst_req); // R10
endmodule

bind wdk_top wdk_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wdt_off (cfg_wdt_off),
    .ctl_unlock  (ctl_unlock),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .wdt_rst_req (wdt_rst_req),
    .ctl_flag    (ctl_flag),
    .ctl_en      (ctl_en),
    .ctl_sel     (ctl_sel)
);

// File: tb/test_wdk_top.sv
`timescale 1ns/1ps
module test_wdk_top;
    localparam int CNT_W = 4;
    localparam int BASE  = 1 << CNT_W;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b1;
    logic       cfg_wdt_off = 1'b0;
    logic       ctl_unlock = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       wdt_rst_req;

    int cyc = 0;
    int n_checks = 0;
    int n_errors = 0;
    int exp_q[$];
    logic prev_req = 1'b0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    wdk_top #(.CNT_W(CNT_W)) i_wdk_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .cfg_wdt_off (cfg_wdt_off),
        .ctl_unlock  (ctl_unlock),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdt_rst_req (wdt_rst_req)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // monitor: pops expected pulse cycles
    always @(negedge clk) begin
        if (rst_n && wdt_rst_req) begin
            if (prev_req) check("R2 pulse width", 2, 1);
            if (exp_q.size() == 0) begin
                check("R2 R5 R6 R10 unexpected request at cycle", cyc, -1);
            end else begin
                check("R2 request cycle", cyc, exp_q.pop_front());
            end
        end
        prev_req <= wdt_rst_req;
    end

    always @(negedge clk) begin
        if (cyc > 20000 && !done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run hung at cycle %0d expected below 20000", cyc);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic wr(input logic a, input logic [7:0] d, output int mark);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        mark = cyc;
    endtask

    task automatic rd(input logic a, input int exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, int'(bus_rdata), exp);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    initial begin
        int m, m2, k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 request low after reset", int'(wdt_rst_req), 0);
        rd(1'b0, 8'h04, "R1 control reset value");
        rd(1'b1, 8'h00, "R8 key reads zero");

        // R2: select 0, two back-to-back periods, flag set
        wr(1'b0, 8'h40, m);
        exp_q.push_back(m + BASE);
        exp_q.push_back(m + 2 * BASE);
        wait_until(m + 2 * BASE + 2);
        rd(1'b0, 8'hC0, "R4 flag set after timeout");
        wr(1'b0, 8'h00, m2);
        rd(1'b0, 8'h00, "R4 software clears flag");
        repeat (60) @(negedge clk); // R10: disabled, monitor flags any pulse

        // R3: wrong key ignored, right key restarts
        wr(1'b0, 8'h41, m);
        exp_q.push_back(m + 2 * BASE);
        wait_until(m + 10);
        wr(1'b1, 8'h12, k);
        wait_until(m + 2 * BASE + 13);
        wr(1'b1, 8'h55, k);
        exp_q.push_back(k + 2 * BASE);
        rd(1'b1, 8'h00, "R8 key reads zero after write");
        wait_until(k + 2 * BASE + 2);
        rd(1'b0, 8'hC1, "R4 flag survives timeout");
        wr(1'b0, 8'h00, m2);

        // R7: divider change restarts period
        wr(1'b0, 8'h44, m);
        wait_until(m + 100);
        wr(1'b0, 8'h43, m2);
        exp_q.push_back(m2 + 8 * BASE);
        wait_until(m2 + 8 * BASE + 2);
        wr(1'b0, 8'h00, m2);

        // R6: locked write ignored
        ctl_unlock = 1'b0;
        wr(1'b0, 8'h40, m);
        rd(1'b0, 8'h00, "R6 locked write ignored");
        repeat (40) @(negedge clk);
        ctl_unlock = 1'b1;

        // R5: force-off overrides enable
        cfg_wdt_off = 1'b1;
        wr(1'b0, 8'h40, m);
        rd(1'b0, 8'h40, "R5 enable bit stored while forced off");
        repeat (50) @(negedge clk);
        cfg_wdt_off = 1'b0;
        m = cyc;
        exp_q.push_back(m + BASE);
        wait_until(m + BASE + 4);
        wr(1'b0, 8'h00, m2);

        // R9: no ticks, no progress
        tick_en = 1'b0;
        wr(1'b0, 8'h40, m);
        repeat (100) @(negedge clk);
        tick_en = 1'b1;
        m = cyc;
        exp_q.push_back(m + BASE);
        wait_until(m + BASE + 4);
        rd(1'b0, 8'hC0, "R9 flag after gated period");

        // R4 R1: external reset clears flag
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(1'b0, 8'h04, "R4 reset clears flag R1");
        repeat (5) @(negedge clk);
        check("R2 all expected requests seen", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule